// File: doc/BRIEF.md
# MMC boot acknowledge timeout monitor

This block runs the boot phase of a host-side MMC-style card port. After the supply is reported stable, it waits out a minimum settling count and then reports that boot may begin. A boot request is accepted in one of two styles. In the first, it signals a one-cycle request to issue the boot-mode reset command. In the second, it holds the CMD line low until boot is terminated. It then follows DAT0 through the optional acknowledge token and through each boot data block.

A single programmable down-counter supervises every wait on DAT0. It is loaded when the boot request is accepted, again after the acknowledge token, and again after the end bit of every data block. It is stopped by the next start bit. If the counter already reads zero when it is stopped, a sticky data-CRC error flag is raised. Software clears that flag with a write-one pulse. Terminating boot releases CMD and starts a fixed quiet gap, and no new boot is accepted until the gap has run out.

Top module: `mmc_boot_supervisor`

## Requirements
- R1: `boot_ready_o` rises only after `power_stable_i` has been sampled high on PWR_CLKS (default 74) consecutive rising edges. A boot request made before then is ignored. A low `power_stable_i` drops `boot_ready_o` on the next edge.
- R2: A boot request accepted with `boot_hold_low_i` = 0 gives a single-cycle `cmd_boot_o` pulse in the cycle after the request, and `cmd_low_o` stays 0.
- R3: A boot request accepted with `boot_hold_low_i` = 1 drives `cmd_low_o` high from the cycle after the request. It stays high through the whole boot and falls in the cycle after `boot_end_i` is sampled.
- R4: With `ack_expect_i` = 1, the timer is loaded with `reload_i` when the request is accepted. Let k be the number of whole cycles between acceptance and the first cycle with `dat0_i` = 0. `dcrc_o` becomes 1 in the cycle after that start bit exactly when k >= `reload_i`. A reload of 0 therefore always flags.
- R5: The four DAT0 bits after the acknowledge start bit are compared with 0,1,0 followed by an end bit of 1. On a match, `ack_ok_o` pulses for one cycle after the end bit. On a mismatch, `ack_err_o` pulses instead. In both cases the timer is reloaded for the first data wait.
- R6: The wait from the acknowledge end bit to the first data start bit obeys the same k >= `reload_i` rule, with k counted from the cycle after the end bit.
- R7: A data block is a start bit, then BLK_BYTES*8 + CRC_BITS bits (default 4112), then an end bit. `blk_done_o` pulses in the cycle after the end bit. The wait for the next block's start bit then obeys the k >= `reload_i` rule.
- R8: With `ack_expect_i` = 0, no token is checked. The first zero on DAT0 after the request is taken as a data start bit, timed by the k >= `reload_i` rule.
- R9: `dcrc_o` stays set until a cycle with `dcrc_clr_i` = 1 clears it. If a timeout event falls in the same cycle as the clear, the flag stays 1.
- R10: After `boot_end_i` is sampled, `boot_ready_o` stays 0 for exactly END_CLKS (default 56) cycles. Boot requests during that gap are ignored.
- R11: `boot_end_i` ends boot from any boot phase. A wait that is interrupted this way never raises `dcrc_o`, even if its timer had reached zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_stable_i | input | 1 | Supply reported stable |
| boot_start_i | input | 1 | Request to begin boot (acted on only when ready) |
| boot_hold_low_i | input | 1 | Boot style: 1 = hold CMD low, 0 = issue boot command |
| ack_expect_i | input | 1 | 1 = the card sends an acknowledge token |
| reload_i | input | TMR_W | Wait timer reload value, in clock cycles |
| dat0_i | input | 1 | Sampled DAT0 line |
| boot_end_i | input | 1 | Terminate boot |
| dcrc_clr_i | input | 1 | Write-one clear of the error flag |
| cmd_boot_o | output | 1 | One-cycle request to send the boot-mode reset command |
| cmd_low_o | output | 1 | Hold CMD low |
| boot_ready_o | output | 1 | A boot (or next command) may be issued |
| ack_ok_o | output | 1 | Acknowledge token matched |
| ack_err_o | output | 1 | Acknowledge token mismatched |
| blk_done_o | output | 1 | A boot data block finished |
| dcrc_o | output | 1 | Sticky data-CRC error (wait timeout) flag |

## Verification
The assertions check several rules on every cycle: the boot command request is a single-cycle pulse, the two boot styles never overlap, and CMD low never coexists with the ready indication. They also check that the error flag only falls on a clear, and that losing power removes readiness at once. The exact timing rules can only be shown by bench scenarios, because they need cycle counts measured against the programmed reload. These rules are the k >= reload decision at each of the three kinds of wait, the settling and quiet-gap lengths, the token comparison, the block length, and the clear-versus-set collision.

// File: rtl/mmc_boot_pkg.sv
package mmc_boot_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP     = 3'd0,
    ST_READY     = 3'd1,
    ST_WAIT_ACK  = 3'd2,
    ST_ACK_BITS  = 3'd3,
    ST_WAIT_DATA = 3'd4,
    ST_DATA      = 3'd5,
    ST_END_GAP   = 3'd6
  } boot_st_e;
endpackage

// File: rtl/mmc_boot_gap_cnt.sv
// Counts consecutive enabled cycles; done_o marks the last of CYCLES.
module mmc_boot_gap_cnt #(
  parameter int unsigned CYCLES = 74
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!en_i)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/mmc_boot_wait_tmr.sv
// Reloadable saturating down-counter used for every DAT0 wait.
module mmc_boot_wait_tmr #(
  parameter int unsigned TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TMR_W-1:0] reload_i,
  input  logic             run_i,
  input  logic             stop_i,
  output logic             expired_o
);
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             dec_en;

  assign dec_en = run_i && !stop_i && (cnt_q != '0);

  always_comb begin
    if (load_i)      cnt_d = reload_i;
    else if (dec_en) cnt_d = cnt_q - 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/mmc_boot_seq.sv
// Boot phase sequencer: start style, token check, block framing.
module mmc_boot_seq
  import mmc_boot_pkg::*;
#(
  parameter int unsigned PAY_BITS = 4112
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     power_stable_i,
  input  logic     pwr_done_i,
  input  logic     gap_done_i,
  input  logic     boot_start_i,
  input  logic     hold_low_i,
  input  logic     ack_expect_i,
  input  logic     dat0_i,
  input  logic     boot_end_i,
  input  logic     tmr_expired_i,
  output boot_st_e state_o,
  output logic     tmr_load_o,
  output logic     tmr_run_o,
  output logic     tmr_stop_o,
  output logic     dcrc_set_o,
  output logic     cmd_boot_o,
  output logic     cmd_low_o,
  output logic     ack_ok_o,
  output logic     ack_err_o,
  output logic     blk_done_o
);
  localparam int unsigned BCW = $clog2(PAY_BITS + 1);
  localparam logic [BCW-1:0] PAY_LAST = BCW'(PAY_BITS);
  localparam logic [BCW-1:0] ACK_LAST = BCW'(3);

  boot_st_e       st_q, st_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic [2:0]     sh_q, sh_d;
  logic           low_q, low_d;
  logic           cmdb_q, cmdb_d;
  logic           aok_q, aok_d;
  logic           aerr_q, aerr_d;
  logic           bdone_q, bdone_d;
  logic           load_c, stop_c;
  logic           in_boot;

  assign in_boot = (st_q == ST_WAIT_ACK) || (st_q == ST_ACK_BITS) ||
                   (st_q == ST_WAIT_DATA) || (st_q == ST_DATA);

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    low_d   = low_q;
    cmdb_d  = 1'b0;
    aok_d   = 1'b0;
    aerr_d  = 1'b0;
    bdone_d = 1'b0;
    load_c  = 1'b0;
    stop_c  = 1'b0;
    case (st_q)
      ST_PWRUP: begin
        low_d = 1'b0;
        if (pwr_done_i) st_d = ST_READY;
      end
      ST_READY: begin
        if (boot_start_i) begin
          if (hold_low_i) low_d  = 1'b1;
          else            cmdb_d = 1'b1;
          load_c = 1'b1;
          st_d   = ack_expect_i ? ST_WAIT_ACK : ST_WAIT_DATA;
        end
      end
      ST_WAIT_ACK: begin
        if (!dat0_i) begin
          stop_c = 1'b1;
          bit_d  = '0;
          st_d   = ST_ACK_BITS;
        end
      end
      ST_ACK_BITS: begin
        if (bit_q == ACK_LAST) begin
          if ((sh_q == 3'b010) && dat0_i) aok_d  = 1'b1;
          else                            aerr_d = 1'b1;
          load_c = 1'b1;
          st_d   = ST_WAIT_DATA;
        end else begin
          sh_d  = {sh_q[1:0], dat0_i};
          bit_d = bit_q + 1'b1;
        end
      end
      ST_WAIT_DATA: begin
        if (!dat0_i) begin
          stop_c = 1'b1;
          bit_d  = '0;
          st_d   = ST_DATA;
        end
      end
      ST_DATA: begin
        if (bit_q == PAY_LAST) begin
          bdone_d = 1'b1;
          load_c  = 1'b1;
          st_d    = ST_WAIT_DATA;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
      ST_END_GAP: begin
        if (gap_done_i) st_d = ST_READY;
      end
      default: st_d = ST_PWRUP;
    endcase

    if (boot_end_i && in_boot) begin
      st_d    = ST_END_GAP;
      low_d   = 1'b0;
      load_c  = 1'b0;
      stop_c  = 1'b0;
      aok_d   = 1'b0;
      aerr_d  = 1'b0;
      bdone_d = 1'b0;
    end

    if (!power_stable_i) begin
      st_d    = ST_PWRUP;
      low_d   = 1'b0;
      cmdb_d  = 1'b0;
      load_c  = 1'b0;
      stop_c  = 1'b0;
      aok_d   = 1'b0;
      aerr_d  = 1'b0;
      bdone_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_PWRUP;
      bit_q   <= '0;
      sh_q    <= '0;
      low_q   <= 1'b0;
      cmdb_q  <= 1'b0;
      aok_q   <= 1'b0;
      aerr_q  <= 1'b0;
      bdone_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      low_q   <= low_d;
      cmdb_q  <= cmdb_d;
      aok_q   <= aok_d;
      aerr_q  <= aerr_d;
      bdone_q <= bdone_d;
    end
  end

  assign state_o    = st_q;
  assign tmr_load_o = load_c;
  assign tmr_stop_o = stop_c;
  assign tmr_run_o  = (st_q == ST_WAIT_ACK) || (st_q == ST_WAIT_DATA);
  assign dcrc_set_o = stop_c && tmr_expired_i;
  assign cmd_boot_o = cmdb_q;
  assign cmd_low_o  = low_q;
  assign ack_ok_o   = aok_q;
  assign ack_err_o  = aerr_q;
  assign blk_done_o = bdone_q;
endmodule

// File: rtl/mmc_boot_supervisor.sv
module mmc_boot_supervisor
  import mmc_boot_pkg::*;
#(
  parameter int unsigned BLK_BYTES = 512,
  parameter int unsigned CRC_BITS  = 16,
  parameter int unsigned TMR_W     = 32,
  parameter int unsigned PWR_CLKS  = 74,
  parameter int unsigned END_CLKS  = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             power_stable_i,
  input  logic             boot_start_i,
  input  logic             boot_hold_low_i,
  input  logic             ack_expect_i,
  input  logic [TMR_W-1:0] reload_i,
  input  logic             dat0_i,
  input  logic             boot_end_i,
  input  logic             dcrc_clr_i,
  output logic             cmd_boot_o,
  output logic             cmd_low_o,
  output logic             boot_ready_o,
  output logic             ack_ok_o,
  output logic             ack_err_o,
  output logic             blk_done_o,
  output logic             dcrc_o
);
  localparam int unsigned PAY_BITS = BLK_BYTES * 8 + CRC_BITS;

  boot_st_e state;
  logic     pwr_done, gap_done, gap_en;
  logic     tmr_load, tmr_run, tmr_stop, tmr_expired;
  logic     dcrc_set;
  logic     dcrc_q, dcrc_d;

  assign gap_en = (state == ST_END_GAP);

  mmc_boot_gap_cnt #(.CYCLES(PWR_CLKS)) u_pwr_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (power_stable_i),
    .done_o (pwr_done)
  );

  mmc_boot_gap_cnt #(.CYCLES(END_CLKS)) u_end_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (gap_en),
    .done_o (gap_done)
  );

  mmc_boot_wait_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .reload_i  (reload_i),
    .run_i     (tmr_run),
    .stop_i    (tmr_stop),
    .expired_o (tmr_expired)
  );

  mmc_boot_seq #(.PAY_BITS(PAY_BITS)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .power_stable_i (power_stable_i),
    .pwr_done_i     (pwr_done),
    .gap_done_i     (gap_done),
    .boot_start_i   (boot_start_i),
    .hold_low_i     (boot_hold_low_i),
    .ack_expect_i   (ack_expect_i),
    .dat0_i         (dat0_i),
    .boot_end_i     (boot_end_i),
    .tmr_expired_i  (tmr_expired),
    .state_o        (state),
    .tmr_load_o     (tmr_load),
    .tmr_run_o      (tmr_run),
    .tmr_stop_o     (tmr_stop),
    .dcrc_set_o     (dcrc_set),
    .cmd_boot_o     (cmd_boot_o),
    .cmd_low_o      (cmd_low_o),
    .ack_ok_o       (ack_ok_o),
    .ack_err_o      (ack_err_o),
    .blk_done_o     (blk_done_o)
  );

  // Sticky error flag: a new event wins over a clear in the same cycle.
  always_comb begin
    if (dcrc_set)        dcrc_d = 1'b1;
    else if (dcrc_clr_i) dcrc_d = 1'b0;
    else                 dcrc_d = dcrc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcrc_q <= 1'b0;
    else        dcrc_q <= dcrc_d;
  end

  assign dcrc_o       = dcrc_q;
  assign boot_ready_o = (state == ST_READY);
endmodule

// File: rtl/mmc_boot_supervisor_chk.sv
module mmc_boot_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic power_stable_i,
  input logic dcrc_clr_i,
  input logic cmd_boot_o,
  input logic cmd_low_o,
  input logic boot_ready_o,
  input logic ack_ok_o,
  input logic ack_err_o,
  input logic blk_done_o,
  input logic dcrc_o
);
  p_pwr_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !power_stable_i |=> !boot_ready_o);

  p_ready_needs_pwr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_ready_o) |-> $past(power_stable_i));

  p_cmd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_boot_o |=> !cmd_boot_o);

  p_styles_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_boot_o |-> !cmd_low_o);

  p_low_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_low_o |-> !boot_ready_o);

  p_ack_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok_o |-> (!ack_err_o && !blk_done_o));

  p_blk_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done_o |=> !blk_done_o);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dcrc_o && !dcrc_clr_i) |=> dcrc_o);

  p_gap_after_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_low_o) |-> !boot_ready_o);
endmodule

bind mmc_boot_supervisor mmc_boot_supervisor_chk u_chk (.*);

// File: tb/mmc_boot_supervisor_bench.sv
`timescale 1ns/1ps
module mmc_boot_supervisor_bench;
  localparam int PAY = 512 * 8 + 16;
  localparam int PWR = 74;
  localparam int GAP = 56;

  logic        clk, rst_n;
  logic        power_stable_i, boot_start_i, boot_hold_low_i, ack_expect_i;
  logic [31:0] reload_i;
  logic        dat0_i, boot_end_i, dcrc_clr_i;
  logic        cmd_boot_o, cmd_low_o, boot_ready_o;
  logic        ack_ok_o, ack_err_o, blk_done_o, dcrc_o;

  int checks = 0;
  int errors = 0;

  mmc_boot_supervisor u_mmc_boot_supervisor (
    .clk(clk), .rst_n(rst_n), .power_stable_i(power_stable_i),
    .boot_start_i(boot_start_i), .boot_hold_low_i(boot_hold_low_i),
    .ack_expect_i(ack_expect_i), .reload_i(reload_i), .dat0_i(dat0_i),
    .boot_end_i(boot_end_i), .dcrc_clr_i(dcrc_clr_i),
    .cmd_boot_o(cmd_boot_o), .cmd_low_o(cmd_low_o), .boot_ready_o(boot_ready_o),
    .ack_ok_o(ack_ok_o), .ack_err_o(ack_err_o), .blk_done_o(blk_done_o),
    .dcrc_o(dcrc_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_flag(input int k, input int r);
    return k >= r;
  endfunction

  // Drive DAT0 and clear for one cycle; return at the following negedge.
  task automatic drive(input logic b, input logic clr);
    dat0_i = b;
    dcrc_clr_i = clr;
    @(negedge clk);
    dcrc_clr_i = 1'b0;
  endtask

  task automatic interval(input int k, input int r, input string tag, input logic clr_on_start);
    for (int i = 0; i < k; i++) drive(1'b1, 1'b0);
    drive(1'b0, clr_on_start);
    chk(tag, dcrc_o, clr_on_start ? 1'b1 : exp_flag(k, r));
  endtask

  task automatic payload(input logic clr_first);
    for (int i = 0; i < PAY; i++) drive(1'($urandom % 2), clr_first && (i == 0));
  endtask

  task automatic start_boot(input logic hold);
    boot_hold_low_i = hold;
    boot_start_i = 1'b1;
    drive(1'b1, 1'b1);
    boot_start_i = 1'b0;
    chk("R2 boot command pulse", cmd_boot_o, !hold);
    chk("R3 cmd held low", cmd_low_o, hold);
  endtask

  task automatic finish_boot(input logic clr, input logic exp_dcrc);
    int n = 0;
    logic stray = 1'b0;
    boot_end_i = 1'b1;
    drive(1'b1, clr);
    boot_end_i = 1'b0;
    chk("R3 cmd released", cmd_low_o, 1'b0);
    chk("R11 no flag on abort", dcrc_o, exp_dcrc);
    while (!boot_ready_o && n < 1000) begin
      boot_start_i = (n == 0);
      drive(1'b1, 1'b0);
      boot_start_i = 1'b0;
      if (cmd_boot_o || cmd_low_o) stray = 1'b1;
      n++;
    end
    chk("R10 quiet gap length", n, GAP);
    chk("R10 start ignored in gap", stray, 1'b0);
  endtask

  task automatic session(input logic hold, input logic acken, input logic good,
                         input int r, input int ka, input int kf, input int nblk);
    reload_i = r;
    ack_expect_i = acken;
    start_boot(hold);
    if (acken) begin
      interval(ka, r, "R4 ack wait", 1'b0);
      drive(1'b0, 1'b1);
      drive(1'b1, 1'b0);
      drive(good ? 1'b0 : 1'b1, 1'b0);
      drive(1'b1, 1'b0);
      chk("R5 token ok", ack_ok_o, good);
      chk("R5 token err", ack_err_o, !good);
      interval(kf, r, "R6 first data wait", 1'b0);
    end else begin
      interval(kf, r, "R8 no-ack data wait", 1'b0);
    end
    for (int b = 0; b < nblk; b++) begin
      payload(1'b1);
      drive(1'b1, 1'b0);
      chk("R7 block done", blk_done_o, 1'b1);
      chk("R3 low held through block", cmd_low_o, hold);
      interval(int'($urandom_range(0, 2 * r + 2)), r, "R7 next block wait", 1'b0);
    end
    finish_boot(1'b1, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h1b00_7a5e));
    rst_n = 1'b0; power_stable_i = 1'b0; boot_start_i = 1'b0; boot_hold_low_i = 1'b0;
    ack_expect_i = 1'b1; reload_i = '0; dat0_i = 1'b1; boot_end_i = 1'b0; dcrc_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", boot_ready_o, 1'b0);
    chk("R9 reset flag", dcrc_o, 1'b0);
    chk("R2 reset cmd", {cmd_boot_o, cmd_low_o}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: request before power is stable is ignored
    boot_start_i = 1'b1;
    drive(1'b1, 1'b0);
    boot_start_i = 1'b0;
    chk("R1 early start ignored", {cmd_boot_o, cmd_low_o, boot_ready_o}, 3'b000);

    // R1: settling count; high on edges 1..PWR, ready seen after edge PWR
    power_stable_i = 1'b1;
    n = 0;
    @(negedge clk);
    while (!boot_ready_o && n < 1000) begin n++; @(negedge clk); end
    chk("R1 settling length", n, PWR - 1);

    // Directed corners
    session(1'b0, 1'b1, 1'b1, 6, 5, 6, 1);   // R4 just in time, R6 just late
    session(1'b1, 1'b0, 1'b1, 0, 0, 0, 1);   // R8 with zero reload
    session(1'b0, 1'b1, 1'b0, 3, 9, 0, 0);   // R5 bad token
    session(1'b1, 1'b1, 1'b1, 1, 0, 1, 0);   // R4/R6 boundaries at reload 1

    // Random sessions
    for (int s = 0; s < 5; s++) begin
      int r = int'($urandom_range(0, 20));
      session(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), r,
              int'($urandom_range(0, 2 * r + 2)), int'($urandom_range(0, 2 * r + 2)),
              int'($urandom_range(0, 1)));
    end

    // R11: abort a wait whose timer already reached zero
    reload_i = 0;
    ack_expect_i = 1'b1;
    start_boot(1'b0);
    repeat (4) drive(1'b1, 1'b0);
    finish_boot(1'b0, 1'b0);
    chk("R11 flag after gap", dcrc_o, 1'b0);

    // R9: set wins over clear, then a lone clear
    reload_i = 0;
    ack_expect_i = 1'b0;
    start_boot(1'b0);
    interval(0, 0, "R9 first set", 1'b0);
    payload(1'b0);
    drive(1'b1, 1'b0);
    interval(0, 0, "R9 set beats clear", 1'b1);
    drive(1'b1, 1'b1);
    chk("R9 clear", dcrc_o, 1'b0);
    finish_boot(1'b0, 1'b0);

    // R1: power loss drops readiness
    power_stable_i = 1'b0;
    drive(1'b1, 1'b0);
    chk("R1 power loss", boot_ready_o, 1'b0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule